// File: doc/BRIEF.md
# Interrupt Trace and Catch Unit

This unit watches the interrupt traffic of a processor core for debugging purposes. A free-running cycle counter gives every event a timestamp. Whenever a vector's pending-set bit is high in a cycle, the unit stores that cycle as the vector's most recent raise time and bumps a per-vector raise counter. Whenever the core accepts an interrupt, the unit writes one trace record into a circular history buffer. The record holds the vector number, the acceptance cycle and the stored raise cycle, so that the response latency can be recovered later.

A debugger walks the history through a small read port, starting at the newest record and stepping back one record per request. Each record comes with its latency. The walk ends at the first record that was never written, or after one full lap of the buffer.

Every vector also carries a 2-bit catch setting. Through it, a raise of that vector, an acceptance of it, or either one can pull a halt request. The halt request stays high until the debugger resumes the core.

Top module: `irq_trace_unit`

## Requirements
- R1: After reset the halt request is low, the cycle counter reads 1, every raise count reads 0, every history record is empty, and a history walk started at once reports no valid record.
- R2: The cycle counter advances by exactly one on every clock edge that is not in reset.
- R3: On every cycle where `raise_set[v]` is high, vector v's raise timestamp becomes the current cycle value and its raise count increments. The count saturates at all ones.
- R4: On a cycle with `take_valid` high, the record at the write position receives `take_vec`, the current cycle and vector `take_vec`'s raise timestamp. The write position then advances and wraps from DEPTH-1 back to 0.
- R5: If `raise_set[take_vec]` is high in the same cycle as the acceptance, the recorded raise cycle equals the current cycle, so the latency is 0.
- R6: A walk begun with `rd_start` first shows the record just below the write position. Each accepted `rd_next` steps to the previous record, wrapping from 0 to DEPTH-1. A walk shows at most DEPTH records.
- R7: The walk stops at the first record whose taken cycle is 0 (`rd_valid` low). An `rd_next` while `rd_valid` is low has no effect.
- R8: `rd_latency` equals `rd_taken` minus `rd_raised` for the record being shown.
- R9: Catch setting bit 0 means catch on raise. A raise of a vector whose bit 0 is set drives `halt_req` high in that same cycle.
- R10: Catch setting bit 1 means catch on acceptance. An acceptance of a vector whose bit 1 is set drives `halt_req` high in the same cycle as `take_valid`, before the acceptance completes.
- R11: Once raised, `halt_req` stays high until a cycle with `resume` high. If a new catch event occurs in the resume cycle, the request stays set.
- R12: A vector whose catch setting is 0 never causes a halt request. A new setting written with `mode_we` takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raise_set | input | NVEC | Per-vector pending-set strobe for this cycle |
| take_valid | input | 1 | The core accepts an interrupt this cycle |
| take_vec | input | VW | Number of the vector being accepted |
| mode_we | input | 1 | Write strobe for a catch setting |
| mode_vec | input | VW | Vector whose catch setting is written |
| mode_val | input | 2 | New catch setting (bit 0 raise, bit 1 accept) |
| resume | input | 1 | Clears the sticky halt request |
| halt_req | output | 1 | Halt request toward the core |
| cnt_sel | input | VW | Vector whose raise count is shown |
| cnt_val | output | CNT_W | Raise count of the selected vector |
| cycle_now | output | CYC_W | Current cycle counter |
| rd_start | input | 1 | Begin a history walk at the newest record |
| rd_next | input | 1 | Step the walk to the next older record |
| rd_valid | output | 1 | The walk shows a written record |
| rd_vec | output | VW | Vector of the shown record |
| rd_taken | output | CYC_W | Acceptance cycle of the shown record |
| rd_raised | output | CYC_W | Raise cycle of the shown record |
| rd_latency | output | CYC_W | Acceptance minus raise cycle |

## Verification
Two situations are the hardest to reach from the ports. The first is a walk that wraps past index 0 and still stops correctly. It needs more acceptances than the buffer depth, interleaved with raises at varying distances, and the random phase produces many of these before the final walks. The second is a catch event that lands in the same cycle as a resume. Directed steps place it exactly there and also put a raise and an acceptance of the same vector in one cycle. A bench model then predicts every record, count and halt level cycle by cycle.

// File: rtl/itc_pkg.sv
// Package: shared constants and index helpers for the interrupt trace unit.
// Assumes ring depths of at least 2.
package itc_pkg;
    // Bit positions of the per-vector catch setting.
    localparam int CATCH_ON_RAISE = 0;
    localparam int CATCH_ON_TAKE  = 1;

    // Circular predecessor of an index in a ring of the given depth.
    function automatic int ring_prev(input int idx, input int depth);
        return (idx == 0) ? depth - 1 : idx - 1;
    endfunction

    // Circular successor of an index in a ring of the given depth.
    function automatic int ring_next(input int idx, input int depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/itc_cycle_stamp.sv
// Cycle counter plus per-vector raise timestamp and saturating raise count.
// Assumes take_vec and cnt_sel stay below NVEC. The counter skips 0 so that
// 0 can mean "never written" elsewhere.
module itc_cycle_stamp #(
    parameter int NVEC  = 8,
    parameter int CYC_W = 32,
    parameter int CNT_W = 8,
    parameter int VW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NVEC-1:0]  raise_set,
    input  logic [VW-1:0]    take_vec,
    input  logic [VW-1:0]    cnt_sel,
    output logic [CYC_W-1:0] cycle_q,
    output logic [CYC_W-1:0] take_raised,
    output logic [CNT_W-1:0] cnt_val
);
    logic [CYC_W-1:0] stamp_q [NVEC];
    logic [CNT_W-1:0] cnt_q   [NVEC];

    // Free-running cycle counter, starts at 1 and never shows 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                cycle_q <= CYC_W'(1);
        else if (&cycle_q)         cycle_q <= CYC_W'(1);
        else                       cycle_q <= cycle_q + CYC_W'(1);
    end

    for (genvar g = 0; g < NVEC; g++) begin : g_vec
        // Per-vector raise timestamp and saturating count.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stamp_q[g] <= '0;
                cnt_q[g]   <= '0;
            end else if (raise_set[g]) begin
                stamp_q[g] <= cycle_q;
                if (!(&cnt_q[g])) cnt_q[g] <= cnt_q[g] + CNT_W'(1);
            end
        end

        // R3: a saturated count never wraps
        p_cnt_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (&cnt_q[g]) |=> (&cnt_q[g]));
        // R3: a count never changes without a raise
        p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !raise_set[g] |=> $stable(cnt_q[g]));
    end

    // Raise time for the record; a same-cycle raise wins (latency 0).
    always_comb begin
        take_raised = raise_set[take_vec] ? cycle_q : stamp_q[take_vec];
    end

    // Raise count readout for the selected vector.
    always_comb begin
        cnt_val = cnt_q[cnt_sel];
    end

    // R2: one step per clock outside reset
    p_cycle_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cycle_q) |=> cycle_q == $past(cycle_q) + CYC_W'(1));
endmodule

// File: rtl/itc_catch.sv
// Per-vector catch settings and the sticky halt request.
// Assumes take_vec and mode_vec stay below NVEC. halt_req includes the
// event of the current cycle, so it is visible before an acceptance completes.
module itc_catch #(
    parameter int NVEC = 8,
    parameter int VW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NVEC-1:0] raise_set,
    input  logic            take_valid,
    input  logic [VW-1:0]   take_vec,
    input  logic            mode_we,
    input  logic [VW-1:0]   mode_vec,
    input  logic [1:0]      mode_val,
    input  logic            resume,
    output logic            halt_req
);
    import itc_pkg::*;

    logic [1:0]      mode_q [NVEC];
    logic [NVEC-1:0] raise_armed;
    logic            catch_hit;
    logic            halt_q;

    for (genvar g = 0; g < NVEC; g++) begin : g_mode
        // Catch setting register of one vector.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 mode_q[g] <= 2'b00;
            else if (mode_we && mode_vec == VW'(g))     mode_q[g] <= mode_val;
        end
        assign raise_armed[g] = mode_q[g][CATCH_ON_RAISE];
    end

    // Catch event of this cycle: an armed raise or an armed acceptance.
    always_comb begin
        catch_hit = (|(raise_set & raise_armed))
                  || (take_valid && mode_q[take_vec][CATCH_ON_TAKE]);
    end

    // Sticky halt level; a new event beats a resume in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) halt_q <= 1'b0;
        else        halt_q <= (halt_q && !resume) || catch_hit;
    end

    assign halt_req = halt_q || catch_hit;

    // R11: the request holds until a resume
    p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q && !resume) |=> halt_q);
    // R9: an event is always followed by the held request
    p_halt_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        catch_hit |=> halt_q);
    // R12: no request without an event or earlier hold
    p_halt_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_q && !catch_hit) |=> !halt_q);
endmodule

// File: rtl/itc_ring.sv
// Circular history of accepted interrupts and its newest-first walker.
// Assumes DEPTH >= 2. A record with taken cycle 0 counts as unwritten.
module itc_ring #(
    parameter int DEPTH = 8,
    parameter int CYC_W = 32,
    parameter int VW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_valid,
    input  logic [VW-1:0]    take_vec,
    input  logic [CYC_W-1:0] cycle_now,
    input  logic [CYC_W-1:0] take_raised,
    input  logic             rd_start,
    input  logic             rd_next,
    output logic             rd_valid,
    output logic [VW-1:0]    rd_vec,
    output logic [CYC_W-1:0] rd_taken,
    output logic [CYC_W-1:0] rd_raised,
    output logic [CYC_W-1:0] rd_latency
);
    import itc_pkg::*;

    localparam int IW = $clog2(DEPTH);
    localparam int SW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [VW-1:0]    vec;
        logic [CYC_W-1:0] taken;
        logic [CYC_W-1:0] raised;
    } rec_t;

    rec_t          ring_q [DEPTH];
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] rd_ptr;
    logic [SW-1:0] rd_steps;
    rec_t          shown;

    // Record writer and write position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            for (int i = 0; i < DEPTH; i++) ring_q[i] <= '0;
        end else if (take_valid) begin
            ring_q[wr_idx] <= '{vec: take_vec, taken: cycle_now, raised: take_raised};
            wr_idx         <= IW'(ring_next(int'(wr_idx), DEPTH));
        end
    end

    // Walker position and number of records already stepped over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            rd_steps <= SW'(DEPTH);
        end else if (rd_start) begin
            rd_ptr   <= IW'(ring_prev(int'(wr_idx), DEPTH));
            rd_steps <= '0;
        end else if (rd_next && rd_valid) begin
            rd_ptr   <= IW'(ring_prev(int'(rd_ptr), DEPTH));
            rd_steps <= rd_steps + SW'(1);
        end
    end

    // Readout of the record under the walker.
    always_comb begin
        shown      = ring_q[rd_ptr];
        rd_valid   = (rd_steps < SW'(DEPTH)) && (shown.taken != '0);
        rd_vec     = shown.vec;
        rd_taken   = shown.taken;
        rd_raised  = shown.raised;
        rd_latency = shown.taken - shown.raised;
    end

    // R4: write position holds when nothing is accepted
    p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !take_valid |=> $stable(wr_idx));
    // R7: a stopped walk does not move
    p_walk_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && !rd_start) |=> $stable(rd_ptr));
    // R6: the walk never exceeds one lap
    p_walk_lap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_steps <= SW'(DEPTH));
endmodule

// File: rtl/irq_trace_unit.sv
// Top of the interrupt trace and catch unit: stamps raises, records
// acceptances in a history ring, and raises a sticky halt on catch events.
// Assumes NVEC is a power of two so every vector number is in range.
module irq_trace_unit #(
    parameter int NVEC  = 8,
    parameter int DEPTH = 8,
    parameter int CYC_W = 32,
    parameter int CNT_W = 8,
    localparam int VW   = $clog2(NVEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NVEC-1:0]  raise_set,
    input  logic             take_valid,
    input  logic [VW-1:0]    take_vec,
    input  logic             mode_we,
    input  logic [VW-1:0]    mode_vec,
    input  logic [1:0]       mode_val,
    input  logic             resume,
    output logic             halt_req,
    input  logic [VW-1:0]    cnt_sel,
    output logic [CNT_W-1:0] cnt_val,
    output logic [CYC_W-1:0] cycle_now,
    input  logic             rd_start,
    input  logic             rd_next,
    output logic             rd_valid,
    output logic [VW-1:0]    rd_vec,
    output logic [CYC_W-1:0] rd_taken,
    output logic [CYC_W-1:0] rd_raised,
    output logic [CYC_W-1:0] rd_latency
);
    logic [CYC_W-1:0] take_raised;

    itc_cycle_stamp #(.NVEC(NVEC), .CYC_W(CYC_W), .CNT_W(CNT_W), .VW(VW)) u_stamp (
        .clk(clk), .rst_n(rst_n), .raise_set(raise_set), .take_vec(take_vec),
        .cnt_sel(cnt_sel), .cycle_q(cycle_now), .take_raised(take_raised),
        .cnt_val(cnt_val)
    );

    itc_catch #(.NVEC(NVEC), .VW(VW)) u_catch (
        .clk(clk), .rst_n(rst_n), .raise_set(raise_set), .take_valid(take_valid),
        .take_vec(take_vec), .mode_we(mode_we), .mode_vec(mode_vec),
        .mode_val(mode_val), .resume(resume), .halt_req(halt_req)
    );

    itc_ring #(.DEPTH(DEPTH), .CYC_W(CYC_W), .VW(VW)) u_ring (
        .clk(clk), .rst_n(rst_n), .take_valid(take_valid), .take_vec(take_vec),
        .cycle_now(cycle_now), .take_raised(take_raised), .rd_start(rd_start),
        .rd_next(rd_next), .rd_valid(rd_valid), .rd_vec(rd_vec),
        .rd_taken(rd_taken), .rd_raised(rd_raised), .rd_latency(rd_latency)
    );

    // R5: a same-cycle raise and acceptance record zero latency
    p_same_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && raise_set[take_vec]) |-> take_raised == cycle_now);
endmodule

// File: tb/irq_trace_unit_bench.sv
module irq_trace_unit_bench;
    localparam int NV = 8;
    localparam int D  = 8;
    localparam int CW = 32;
    localparam int KW = 8;
    localparam int VW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NV-1:0] raise_set = '0;
    logic take_valid = 1'b0;
    logic [VW-1:0] take_vec = '0;
    logic mode_we = 1'b0;
    logic [VW-1:0] mode_vec = '0;
    logic [1:0] mode_val = '0;
    logic resume = 1'b0;
    logic halt_req;
    logic [VW-1:0] cnt_sel = '0;
    logic [KW-1:0] cnt_val;
    logic [CW-1:0] cycle_now;
    logic rd_start = 1'b0, rd_next = 1'b0;
    logic rd_valid;
    logic [VW-1:0] rd_vec;
    logic [CW-1:0] rd_taken, rd_raised, rd_latency;

    irq_trace_unit #(.NVEC(NV), .DEPTH(D), .CYC_W(CW), .CNT_W(KW)) u_irq_trace_unit (
        .clk(clk), .rst_n(rst_n), .raise_set(raise_set), .take_valid(take_valid),
        .take_vec(take_vec), .mode_we(mode_we), .mode_vec(mode_vec),
        .mode_val(mode_val), .resume(resume), .halt_req(halt_req),
        .cnt_sel(cnt_sel), .cnt_val(cnt_val), .cycle_now(cycle_now),
        .rd_start(rd_start), .rd_next(rd_next), .rd_valid(rd_valid),
        .rd_vec(rd_vec), .rd_taken(rd_taken), .rd_raised(rd_raised),
        .rd_latency(rd_latency)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    // Bench model state
    logic [CW-1:0] bcycle = 1;
    logic [CW-1:0] m_stamp [NV];
    int            m_cnt   [NV];
    logic [1:0]    m_mode  [NV];
    logic [VW-1:0] m_vec   [D];
    logic [CW-1:0] m_taken [D];
    logic [CW-1:0] m_raised[D];
    int            m_wr = 0;
    logic          m_sticky = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) bcycle <= 1;
        else        bcycle <= bcycle + 1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic logic pred_event(input logic [NV-1:0] r, input logic tk,
                                        input logic [VW-1:0] tv);
        logic e = 1'b0;
        for (int v = 0; v < NV; v++) if (r[v] && m_mode[v][0]) e = 1'b1;
        if (tk && m_mode[tv][1]) e = 1'b1;
        return e;
    endfunction

    // One cycle of stimulus; called at a falling edge, returns at the next one.
    task automatic step(input logic [NV-1:0] r, input logic tk, input logic [VW-1:0] tv,
                        input logic mw, input logic [VW-1:0] mv, input logic [1:0] mval,
                        input logic res, input string tag);
        logic ev;
        raise_set = r; take_valid = tk; take_vec = tv;
        mode_we = mw; mode_vec = mv; mode_val = mval; resume = res;
        #1;
        ev = pred_event(r, tk, tv);
        check(tag, halt_req, m_sticky | ev);
        if (tk) begin
            m_vec[m_wr]    = tv;
            m_taken[m_wr]  = bcycle;
            m_raised[m_wr] = r[tv] ? bcycle : m_stamp[tv];
            m_wr = (m_wr + 1) % D;
        end
        for (int v = 0; v < NV; v++) if (r[v]) begin
            m_stamp[v] = bcycle;
            if (m_cnt[v] < 255) m_cnt[v]++;
        end
        if (mw) m_mode[mv] = mval;
        m_sticky = (m_sticky & ~res) | ev;
        @(negedge clk);
        raise_set = '0; take_valid = 0; mode_we = 0; resume = 0;
    endtask

    task automatic check_count(input int v, input string tag);
        cnt_sel = VW'(v);
        #1;
        check(tag, cnt_val, m_cnt[v]);
    endtask

    // Walk the history and compare against the model, newest first.
    task automatic walk(input string tag);
        int idx = (m_wr + D - 1) % D;
        logic stopped = 1'b0;
        rd_start = 1; @(negedge clk); rd_start = 0; #1;
        for (int i = 0; i <= D; i++) begin
            logic expv = (i < D) && !stopped && (m_taken[idx] != 0);
            check({tag, " R6 valid"}, rd_valid, expv);
            if (expv) begin
                check({tag, " R4 vec"}, rd_vec, m_vec[idx]);
                check({tag, " R4 taken"}, rd_taken, m_taken[idx]);
                check({tag, " R4 raised"}, rd_raised, m_raised[idx]);
                check({tag, " R8 latency"}, rd_latency, m_taken[idx] - m_raised[idx]);
                idx = (idx + D - 1) % D;
            end else if (stopped) begin
                break;
            end else begin
                stopped = 1'b1;  // R7: one more rd_next must leave it stopped
            end
            rd_next = 1; @(negedge clk); rd_next = 0; #1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int v = 0; v < NV; v++) begin m_stamp[v] = 0; m_cnt[v] = 0; m_mode[v] = 0; end
        for (int i = 0; i < D; i++) begin m_vec[i] = 0; m_taken[i] = 0; m_raised[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        check("R1 halt", halt_req, 0);
        check("R1 cycle", cycle_now, 1);
        for (int v = 0; v < NV; v++) check_count(v, "R1 count");
        walk("R1 walk");
        // R2 counter steps
        check("R2 cycle", cycle_now, bcycle);
        step('0, 0, 0, 0, 0, 0, 0, "R2 idle");
        check("R2 cycle", cycle_now, bcycle);

        // R9 catch on raise, then R11 resume
        step('0, 0, 0, 1, 3'd2, 2'b01, 0, "R9 setup");
        step(8'h04, 0, 0, 0, 0, 0, 0, "R9 raise halts");
        step('0, 0, 0, 0, 0, 0, 0, "R11 held");
        step('0, 0, 0, 0, 0, 0, 1, "R11 resume");
        check("R11 cleared", halt_req, 0);
        // R12 setting 0 never halts
        step(8'h08, 0, 0, 0, 0, 0, 0, "R12 raise off");
        step('0, 1, 3'd3, 0, 0, 0, 0, "R12 take off");
        check("R12 no halt", halt_req, 0);
        // R10 catch on acceptance only
        step('0, 0, 0, 1, 3'd4, 2'b10, 0, "R10 setup");
        step(8'h10, 0, 0, 0, 0, 0, 0, "R10 raise ignored");
        check("R10 raise no halt", halt_req, 0);
        repeat (3) step('0, 0, 0, 0, 0, 0, 0, "R10 gap");
        step('0, 1, 3'd4, 0, 0, 0, 0, "R10 take halts");
        // R11 event in the resume cycle keeps the request
        step(8'h04, 0, 0, 0, 0, 0, 1, "R11 resume with event");
        check("R11 still set", halt_req, 1);
        step('0, 0, 0, 0, 0, 0, 1, "R11 resume");
        // R5 same-cycle raise and acceptance
        step(8'h20, 1, 3'd5, 0, 0, 0, 0, "R5 same cycle");
        // R7 partial walk stops at empty record
        walk("R7 partial");
        check_count(2, "R3 count v2");

        // Random phase
        for (int n = 0; n < 400; n++) begin
            logic [NV-1:0] r = ($urandom % 3 == 0) ? NV'($urandom & $urandom) : '0;
            logic tk = ($urandom % 10) < 3;
            logic mw = ($urandom % 12) == 0;
            logic res = ($urandom % 6) == 0;
            step(r, tk, VW'($urandom), mw, VW'($urandom), 2'($urandom), res, "R11 random halt");
            check_count(int'($urandom % NV), "R3 random count");
            if (n % 97 == 96) walk("R6 random");
        end
        walk("R6 wrapped");

        // R3 saturation on vector 7
        step('0, 0, 0, 1, 3'd7, 2'b00, 1, "R3 setup");
        for (int k = 0; k < 260; k++) step(8'h80, 0, 0, 0, 0, 0, 0, "R3 sat");
        check_count(7, "R3 saturated");
        step('0, 1, 3'd7, 0, 0, 0, 0, "R4 take v7");
        walk("R8 final");
        check("R2 cycle end", cycle_now, bcycle);

        done = 1'b1;
        finish_run();
    end
endmodule